// File: doc/BRIEF.md
# Row-Column Static RAM

A single-port static RAM whose words are kept in a two-dimensional array. Each row of the array holds several data-width groups side by side. The address is split in two. The upper field drives a decoder that raises exactly one wordline. The lower field picks which group of the selected row reaches the data port. Writes happen on the rising clock edge. Reads are combinational: the output follows the address without waiting for a clock.

A chip select gates everything. While it is low, no wordline rises, nothing is written, and the output is held at zero with its valid flag cleared. This zero output stands in for a floating pin.

The geometry is set by three parameters: word width, row address bits and column address bits. The same code builds a 16-word by 1-bit memory laid out as 4 rows of 4 single-bit groups. It also builds a 32K-word by 8-bit memory laid out as 512 rows of 64 byte-wide groups. Seen from outside, either build behaves like a plain RAM with the same word count.

Top module: `rc_sram`

## Requirements
- R1: The address is {row, column}. The row field is the upper ROW_BITS bits and the column field is the lower COL_BITS bits. Word address a lives in row a>>COL_BITS, group a mod 2^COL_BITS. From outside, the memory acts as a flat array of 2^(ROW_BITS+COL_BITS) words.
- R2: When cs=1 and we=1 at a rising clock edge, din is stored at addr.
- R3: While cs=1, exactly one wordline is active: the one whose index equals the row field.
- R4: While cs=0, no wordline is active, dout is all zeros and dout_vld is 0.
- R5: A read is combinational. While cs=1, dout equals the word stored at addr in the same cycle and dout_vld is 1. A word written at an edge is visible right after that edge.
- R6: While cs=0, we and din are ignored. No word changes.
- R7: A write changes only the addressed group. Other groups in the same row, and all other rows, keep their values.
- R8: While cs=1 and we=0, no word changes, whatever din holds.
- R9: The geometry is set by parameters. Both 4x4 single-bit (16x1) and 512x64 byte-wide (32Kx8) builds meet R1 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge |
| cs | input | 1 | Chip select, active high |
| we | input | 1 | Write enable, active high |
| addr | input | ROW_BITS+COL_BITS | Word address, row field on top |
| din | input | WORD_W | Write data |
| dout | output | WORD_W | Read data, zero while deselected |
| dout_vld | output | 1 | High while read data is driven |

## Verification
Some properties are checked by assertions on every cycle:
- the wordline vector is one-hot while selected and all zeros while deselected;
- a row whose wordline is not written keeps its contents;
- a write is readable at the same address on the next cycle;
- a deselected port outputs zeros.

Other properties only the bench can show, by comparing reads against its own flat word array:
- the address split gives the same result as a flat RAM, across both geometries;
- the group boundaries inside a row are placed correctly;
- writes attempted with chip select low, or with write enable low, leave the contents unchanged.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  // Row index of a flat word address.
  function automatic int unsigned rcs_row_of(input int unsigned a, input int unsigned col_bits);
    return a >> col_bits;
  endfunction

  // Group index of a flat word address within its row.
  function automatic int unsigned rcs_col_of(input int unsigned a, input int unsigned col_bits);
    return a & ((32'd1 << col_bits) - 32'd1);
  endfunction

  // Lowest bit of a group inside a row vector.
  function automatic int unsigned rcs_group_lsb(input int unsigned col, input int unsigned word_w);
    return col * word_w;
  endfunction

endpackage

// File: rtl/rcs_row_decoder.sv
module rcs_row_decoder #(
  parameter int ROW_BITS = 2,
  localparam int ROWS = 1 << ROW_BITS
) (
  input  logic                en,
  input  logic [ROW_BITS-1:0] row,
  output logic [ROWS-1:0]     wl
);
  for (genvar r = 0; r < ROWS; r++) begin : g_wl
    assign wl[r] = en && (row == ROW_BITS'(r));
  end
endmodule

// File: rtl/rcs_array.sv
module rcs_array #(
  parameter int WORD_W   = 1,
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int COLS    = 1 << COL_BITS,
  localparam int ROW_LEN = COLS * WORD_W
) (
  input  logic                clk,
  input  logic                we,
  input  logic [ROWS-1:0]     wl,
  input  logic [COL_BITS-1:0] col,
  input  logic [WORD_W-1:0]   din,
  output logic [ROW_LEN-1:0]  rd_row
);
  import rcs_pkg::*;

  logic [ROW_LEN-1:0] row_q [ROWS];
  logic [ROWS-1:0]    row_wr;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_wr[r] = we && wl[r];

    always_ff @(posedge clk) begin
      if (row_wr[r])
        row_q[r][rcs_group_lsb(32'(col), WORD_W) +: WORD_W] <= din;
    end

    // R7 (also R6, R8): a row not written this edge keeps its bits
    row_hold_chk: assert property (@(posedge clk) !row_wr[r] |=> $stable(row_q[r]));
  end

  // Wired-OR style read: every row gated by its wordline, then OR-ed
  always_comb begin
    rd_row = '0;
    for (int r = 0; r < ROWS; r++)
      rd_row = rd_row | (row_q[r] & {ROW_LEN{wl[r]}});
  end
endmodule

// File: rtl/rcs_col_select.sv
module rcs_col_select #(
  parameter int WORD_W   = 1,
  parameter int COL_BITS = 2,
  localparam int COLS    = 1 << COL_BITS,
  localparam int ROW_LEN = COLS * WORD_W
) (
  input  logic [ROW_LEN-1:0]  row_bits,
  input  logic [COL_BITS-1:0] col,
  output logic [WORD_W-1:0]   word
);
  import rcs_pkg::*;
  assign word = row_bits[rcs_group_lsb(32'(col), WORD_W) +: WORD_W];
endmodule

// File: rtl/rc_sram.sv
module rc_sram #(
  parameter int WORD_W   = 1,
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int ROW_LEN = (1 << COL_BITS) * WORD_W
) (
  input  logic              clk,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_vld
);
  import rcs_pkg::*;

  logic [ROW_BITS-1:0] row_f;
  logic [COL_BITS-1:0] col_f;
  logic [ROWS-1:0]     wl;
  logic [ROW_LEN-1:0]  sel_row;
  logic [WORD_W-1:0]   sel_word;

  assign row_f = ROW_BITS'(rcs_row_of(32'(addr), COL_BITS));
  assign col_f = COL_BITS'(rcs_col_of(32'(addr), COL_BITS));

  rcs_row_decoder #(.ROW_BITS(ROW_BITS)) u_dec (
    .en(cs), .row(row_f), .wl(wl)
  );

  rcs_array #(.WORD_W(WORD_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_arr (
    .clk(clk), .we(we), .wl(wl), .col(col_f), .din(din), .rd_row(sel_row)
  );

  rcs_col_select #(.WORD_W(WORD_W), .COL_BITS(COL_BITS)) u_col (
    .row_bits(sel_row), .col(col_f), .word(sel_word)
  );

  assign dout     = cs ? sel_word : '0;
  assign dout_vld = cs;

  // R3
  wl_onehot_chk: assert property (@(posedge clk) $onehot0(wl));
  // R3
  wl_select_chk: assert property (@(posedge clk) cs |-> $onehot(wl));
  // R4
  wl_idle_chk: assert property (@(posedge clk) !cs |-> (wl == '0));
  // R4
  out_idle_chk: assert property (@(posedge clk) !dout_vld |-> (dout == '0));
  // R5 (with R2)
  wr_readback_chk: assert property (@(posedge clk)
    (cs && we) ##1 (cs && $stable(addr)) |-> (dout == $past(din)));
endmodule

// File: tb/rc_sram_bench.sv
module rc_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B_WORDS = 32768;

  typedef struct {
    bit         big;
    logic [7:0] exp;
    bit         vld;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       s_cs = 0, s_we = 0;
  logic [3:0] s_addr = 0;
  logic [0:0] s_din = 0, s_dout;
  logic       s_vld;

  logic        b_cs = 0, b_we = 0;
  logic [14:0] b_addr = 0;
  logic [7:0]  b_din = 0, b_dout;
  logic        b_vld;

  rc_sram #(.WORD_W(1), .ROW_BITS(2), .COL_BITS(2)) u_rc_sram (
    .clk(clk), .cs(s_cs), .we(s_we), .addr(s_addr), .din(s_din),
    .dout(s_dout), .dout_vld(s_vld));

  rc_sram #(.WORD_W(8), .ROW_BITS(9), .COL_BITS(6)) u_rc_sram_wide (
    .clk(clk), .cs(b_cs), .we(b_we), .addr(b_addr), .din(b_din),
    .dout(b_dout), .dout_vld(b_vld));

  exp_t       q[$];
  logic [0:0] ref_s [16];
  logic [7:0] ref_b [int];
  int checks = 0, fails = 0;
  bit done = 0;

  // Scoreboard monitor: one expected item per driven cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      logic [7:0] act;
      logic       av;
      it  = q.pop_front();
      act = it.big ? b_dout : {7'b0, s_dout};
      av  = it.big ? b_vld : s_vld;
      checks++;
      if (act !== it.exp || av !== it.vld) begin
        fails++;
        $display("FAIL %s: dout=%h vld=%b expected dout=%h vld=%b",
                 it.req, act, av, it.exp, it.vld);
      end
    end
  end

  function automatic logic [7:0] bref(input int a);
    return ref_b.exists(a) ? ref_b[a] : 8'h00;
  endfunction

  // Driver: applies one cycle and queues the read expected in that cycle
  task automatic drive(input bit big, input bit cs, input bit we,
                       input int a, input logic [7:0] d, input string req);
    exp_t it;
    @(posedge clk); #1;
    it.big = big; it.vld = cs; it.req = req;
    if (big) begin
      b_cs = cs; b_we = we; b_addr = 15'(a); b_din = d;
      s_cs = 0; s_we = 0;
      it.exp = cs ? bref(a) : 8'h00;
      if (cs && we) ref_b[a] = d;
    end else begin
      s_cs = cs; s_we = we; s_addr = 4'(a); s_din = d[0];
      b_cs = 0; b_we = 0;
      it.exp = cs ? {7'b0, ref_s[a]} : 8'h00;
      if (cs && we) ref_s[a] = d[0];
    end
    q.push_back(it);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2;
    // R4: both ports deselected from the start
    checks++;
    if (s_dout !== 1'b0 || s_vld !== 1'b0 || b_dout !== 8'h00 || b_vld !== 1'b0) begin
      fails++;
      $display("FAIL R4: idle outputs s=%b/%b b=%h/%b expected 0/0 0/0",
               s_dout, s_vld, b_dout, b_vld);
    end

    // R1 R2 R5: fill the 16x1 build, then read every word back
    for (int a = 0; a < 16; a++) drive(0, 1, 1, a, 8'((a * 5 + 1) >> 1), "R2 small fill");
    for (int a = 0; a < 16; a++) drive(0, 1, 0, a, 8'h00, "R1 small readback");
    // R6: write attempt while deselected, then read
    drive(0, 0, 1, 5, {7'b0, ~ref_s[5]}, "R4 deselected output");
    drive(0, 1, 0, 5, 8'h00, "R6 cs low write ignored");
    // R8: we low with changing din
    drive(0, 1, 0, 9, {7'b0, ~ref_s[9]}, "R8 read with din toggled");
    drive(0, 1, 0, 9, 8'h00, "R8 no write with we low");
    // R7: write group 2 of row 1 (addr 6), neighbours untouched
    drive(0, 1, 1, 6, {7'b0, ~ref_s[6]}, "R7 write addr 6");
    for (int a = 0; a < 16; a++) drive(0, 1, 0, a, 8'h00, "R7 isolation sweep");
    // R2 R5: random mix on the small build
    for (int i = 0; i < 300; i++)
      drive(0, ($urandom % 4) != 0, $urandom % 2, int'($urandom % 16),
            8'($urandom), "R2 small random");

    // R9 R1: fill the 32Kx8 build (512 rows x 64 groups)
    for (int a = 0; a < B_WORDS; a++)
      drive(1, 1, 1, a, 8'(a) ^ 8'(a >> 7) ^ 8'h5A, "R9 wide fill");
    // R1: row and group boundaries
    drive(1, 1, 0, 0,     8'h00, "R1 wide first word");
    drive(1, 1, 0, 63,    8'h00, "R1 wide row0 last group");
    drive(1, 1, 0, 64,    8'h00, "R1 wide row1 first group");
    drive(1, 1, 0, 32767, 8'h00, "R1 wide last word");
    // R7: write inside row 100, check its neighbours
    drive(1, 1, 1, 100 * 64 + 10, 8'hC3, "R7 wide write");
    for (int c = 8; c < 13; c++) drive(1, 1, 0, 100 * 64 + c, 8'h00, "R7 wide neighbours");
    drive(1, 1, 0, 99 * 64 + 10,  8'h00, "R7 wide row above");
    drive(1, 1, 0, 101 * 64 + 10, 8'h00, "R7 wide row below");
    // R6 R8 on the wide build
    drive(1, 0, 1, 200, 8'hFF, "R4 wide deselected");
    drive(1, 1, 0, 200, 8'hAA, "R6 wide cs low ignored");
    drive(1, 1, 0, 200, 8'h00, "R8 wide we low ignored");
    // R9 R2: random traffic on the wide build
    for (int i = 0; i < 3000; i++)
      drive(1, ($urandom % 5) != 0, $urandom % 2, int'($urandom % B_WORDS),
            8'($urandom), "R9 wide random");

    drive(1, 0, 0, 0, 8'h00, "R4 final idle");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule